// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad that serves a group of 16 lanes at once. Each lane brings its own word address, a write enable and write data. The words are interleaved across 16 single-ported banks. The low bits of a word address pick the bank, and the upper bits pick the row inside that bank.

When every enabled lane lands in a different bank, the group completes in one service cycle. When lanes collide in a bank, the block replays only the colliding lanes in later cycles, so the number of service cycles equals the largest number of enabled lanes that share one bank. A busy output tells the requester to hold off while the group drains. Once the group is complete, all per-lane read results appear together with a one-cycle valid pulse.

Lanes can be masked off. A masked lane adds nothing to the conflict count and cannot modify memory.

Top module: `bank_scratchpad`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are both low.
- R2: For a word address A, the bank is A[3:0] and the row is A[ADDR_W-1:4]. A word written at A is read back unchanged at A, and every address holds its own word.
- R3: A request is taken only in a cycle where `req_valid` is high and `busy` is low. A request presented while `busy` is high is ignored: no lane of it writes memory.
- R4: If every enabled lane targets a different bank, `busy` is high for exactly one cycle after acceptance. This covers unit stride and any one-to-one lane-to-bank permutation.
- R5: `busy` stays high for N cycles after acceptance, where N is the largest count of enabled lanes sharing one bank. A word stride of 2 gives N=2 and a word stride of 8 gives N=8.
- R6: A bank serves at most one lane per cycle. Among the lanes still waiting, it serves the lowest-numbered one first. For example, a read on a lower lane sees memory before a write on a higher lane to the same word, and a read on a higher lane sees it after.
- R7: A lane whose `req_lane_en` bit is 0 is not counted toward N, never writes memory, and returns zero read data.
- R8: Lanes with identical addresses are serialized with no broadcast. After a group of writes to one word, that word holds the data of the highest-numbered enabled lane.
- R9: `rsp_valid` is a one-cycle pulse in the cycle after the last service cycle, and it arrives together with `rsp_rdata` for all lanes. A read lane returns the word it read, and a write lane returns zero. A request with no enabled lane gives `rsp_valid` in the cycle right after acceptance.
- R10: `busy` is low whenever `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_lane_en | input | LANES | Per-lane enable mask |
| req_we | input | LANES | Per-lane write enable |
| req_addr | input | LANES*ADDR_W | Per-lane word address, lane 0 in the low bits |
| req_wdata | input | LANES*DATA_W | Per-lane write data, lane 0 in the low bits |
| busy | output | 1 | Group in service, new requests not taken |
| rsp_valid | output | 1 | One-cycle pulse, read data valid |
| rsp_rdata | output | LANES*DATA_W | Per-lane read data, lane 0 in the low bits |

## Verification
The following properties are checked on every cycle:
- No bank grants more than one lane.
- Only waiting lanes are served.
- The waiting set never grows during service and shrinks on every busy cycle.
- The end of busy always coincides with the response pulse.

Other behaviour can only be shown by the bench's scenarios, through data read back at the ports:
- the exact service-cycle count for unit-stride, permuted, stride-2, stride-8 and same-word patterns;
- the lowest-lane-first order;
- the last-writer-wins result;
- the fact that masked lanes and requests offered while busy leave memory untouched.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // bank index: low bank_bits of the word address
  function automatic int unsigned bank_index(input int unsigned word_addr,
                                             input int unsigned bank_bits);
    return word_addr % (32'd1 << bank_bits);
  endfunction

  // row inside a bank: the address bits above the bank index
  function automatic int unsigned row_index(input int unsigned word_addr,
                                            input int unsigned bank_bits);
    return word_addr >> bank_bits;
  endfunction

endpackage

// File: rtl/sp_bank_store.sv
module sp_bank_store #(
  parameter int ROW_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[row] <= wdata;
  end

  // read of the old contents in the same cycle as the grant
  assign rdata = mem[row];
endmodule

// File: rtl/sp_bank_arbiter.sv
module sp_bank_arbiter #(
  parameter int LANES = 16,
  parameter int BANKS = 16
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*BANK_W-1:0] lane_bank_flat,
  output logic [BANKS-1:0]        bank_active,
  output logic [BANKS*LANE_W-1:0] bank_lane_flat,
  output logic [LANES-1:0]        served
);
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [BANK_W-1:0] lane_bank [LANES];
  logic [LANE_W-1:0] bank_lane [BANKS];

  always_comb begin
    for (int l = 0; l < LANES; l++)
      lane_bank[l] = lane_bank_flat[l*BANK_W +: BANK_W];
  end

  // one priority picker per bank: lowest waiting lane wins
  for (genvar b = 0; b < BANKS; b++) begin : g_pick
    always_comb begin
      bank_active[b] = 1'b0;
      bank_lane[b]   = '0;
      for (int l = LANES-1; l >= 0; l--) begin
        if (pend[l] && (lane_bank[l] == BANK_W'(b))) begin
          bank_active[b] = 1'b1;
          bank_lane[b]   = LANE_W'(l);
        end
      end
    end
    assign bank_lane_flat[b*LANE_W +: LANE_W] = bank_lane[b];
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      served[l] = pend[l] && bank_active[lane_bank[l]] &&
                  (bank_lane[lane_bank[l]] == LANE_W'(l));
  end
endmodule

// File: rtl/bank_scratchpad.sv
module bank_scratchpad #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [LANES-1:0]        req_lane_en,
  input  logic [LANES-1:0]        req_we,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES*DATA_W-1:0] req_wdata,
  output logic                    busy,
  output logic                    rsp_valid,
  output logic [LANES*DATA_W-1:0] rsp_rdata
);
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int ROW_W  = ADDR_W - BANK_W;

  // captured request
  logic [ADDR_W-1:0] addr_q  [LANES];
  logic [DATA_W-1:0] wdata_q [LANES];
  logic [DATA_W-1:0] rdata_q [LANES];
  logic [LANES-1:0]  we_q;
  logic [LANES-1:0]  pend_mask;
  logic              rsp_q;

  // named internal events
  logic                    accept;
  logic [LANES-1:0]        serve_mask;
  logic [LANES-1:0]        pend_next;
  logic                    last_service;
  logic [LANES*BANK_W-1:0] lane_bank_flat;
  logic [BANKS*LANE_W-1:0] bank_lane_flat;
  logic [BANKS-1:0]        bank_active;
  logic [BANK_W-1:0]       lane_bank [LANES];
  logic [ROW_W-1:0]        lane_row  [LANES];
  logic [DATA_W-1:0]       bank_rd   [BANKS];

  assign busy         = |pend_mask;
  assign accept       = req_valid && !busy;
  assign pend_next    = pend_mask & ~serve_mask;
  assign last_service = busy && (pend_next == '0);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_bank[l] = BANK_W'(sp_pkg::bank_index(32'(addr_q[l]), BANK_W));
      lane_row[l]  = ROW_W'(sp_pkg::row_index(32'(addr_q[l]), BANK_W));
      lane_bank_flat[l*BANK_W +: BANK_W] = lane_bank[l];
    end
  end

  sp_bank_arbiter #(.LANES(LANES), .BANKS(BANKS)) u_arb (
    .pend           (pend_mask),
    .lane_bank_flat (lane_bank_flat),
    .bank_active    (bank_active),
    .bank_lane_flat (bank_lane_flat),
    .served         (serve_mask)
  );

  // one single-ported bank per index, steered by its granted lane
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LANE_W-1:0] sel;
    logic              wr;
    assign sel = bank_lane_flat[b*LANE_W +: LANE_W];
    assign wr  = bank_active[b] && we_q[sel];

    sp_bank_store #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .wr_en (wr),
      .row   (lane_row[sel]),
      .wdata (wdata_q[sel]),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_mask <= '0;
      we_q      <= '0;
      rsp_q     <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        addr_q[l]  <= '0;
        wdata_q[l] <= '0;
        rdata_q[l] <= '0;
      end
    end else begin
      rsp_q <= (accept && (req_lane_en == '0)) || last_service;
      if (accept) begin
        pend_mask <= req_lane_en;
        we_q      <= req_we;
        for (int l = 0; l < LANES; l++) begin
          addr_q[l]  <= req_addr[l*ADDR_W +: ADDR_W];
          wdata_q[l] <= req_wdata[l*DATA_W +: DATA_W];
          rdata_q[l] <= '0;
        end
      end else begin
        pend_mask <= pend_next;
        for (int l = 0; l < LANES; l++) begin
          if (serve_mask[l] && !we_q[l]) rdata_q[l] <= bank_rd[lane_bank[l]];
        end
      end
    end
  end

  assign rsp_valid = rsp_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) rsp_rdata[l*DATA_W +: DATA_W] = rdata_q[l];
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int LANES = 16,
  parameter int BANKS = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    rsp_valid,
  input logic [LANES-1:0]        pend,
  input logic [LANES-1:0]        served,
  input logic [LANES*BANK_W-1:0] lane_bank
);
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  // R3
  no_accept_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pend & ~$past(pend)) == '0));

  // R5
  progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(pend) < $countones($past(pend))));

  // R7
  served_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (served & ~pend) == '0);

  // R9
  rsp_at_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  // R10
  rsp_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank_chk
    logic [LANES-1:0] in_bank;
    always_comb begin
      for (int l = 0; l < LANES; l++)
        in_bank[l] = (lane_bank[l*BANK_W +: BANK_W] == BANK_W'(b));
    end
    // R6
    one_grant_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(served & in_bank));
  end
endmodule

bind bank_scratchpad sp_checker #(.LANES(LANES), .BANKS(BANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .pend      (pend_mask),
  .served    (serve_mask),
  .lane_bank (lane_bank_flat)
);

// File: tb/bank_scratchpad_test.sv
`timescale 1ns/1ps
module bank_scratchpad_test;
  localparam int LANES = 16, BANKS = 16, ADDR_W = 10, DATA_W = 32;
  localparam int WORDS = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [LANES-1:0] req_lane_en, req_we;
  logic [LANES*ADDR_W-1:0] req_addr;
  logic [LANES*DATA_W-1:0] req_wdata;
  logic busy, rsp_valid;
  logic [LANES*DATA_W-1:0] rsp_rdata;

  logic [ADDR_W-1:0] t_addr [LANES];
  logic [DATA_W-1:0] t_data [LANES];
  logic              t_en   [LANES];
  logic              t_we   [LANES];
  logic [DATA_W-1:0] ref_mem [WORDS];
  logic [DATA_W-1:0] exp_rd [LANES];

  int total = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      req_lane_en[l] = t_en[l];
      req_we[l]      = t_we[l];
      req_addr[l*ADDR_W +: ADDR_W]  = t_addr[l];
      req_wdata[l*DATA_W +: DATA_W] = t_data[l];
    end
  end

  bank_scratchpad #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lane_en(req_lane_en),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic logic [DATA_W-1:0] rd_lane(input int l);
    return rsp_rdata[l*DATA_W +: DATA_W];
  endfunction

  task automatic clear_lanes();
    for (int l = 0; l < LANES; l++) begin
      t_en[l] = 1'b0; t_we[l] = 1'b0; t_addr[l] = '0; t_data[l] = '0;
    end
  endtask

  // reference: lanes complete in lane order, which matches per-bank lowest-first
  task automatic model_apply();
    for (int l = 0; l < LANES; l++) begin
      exp_rd[l] = '0;
      if (t_en[l]) begin
        if (t_we[l]) ref_mem[t_addr[l]] = t_data[l];
        else         exp_rd[l] = ref_mem[t_addr[l]];
      end
    end
  endtask

  // called at the first negedge after acceptance
  task automatic wait_rsp(input string tag, input int exp_n);
    int k = 1, bc = 0;
    while (!rsp_valid && k < 80) begin
      if (busy) bc++;
      @(negedge clk); k++;
    end
    chk(rsp_valid, {tag, " rsp_valid seen"}, 64'(rsp_valid), 64'd1);
    chk(k == exp_n + 1, {tag, " response cycle"}, 64'(k), 64'(exp_n + 1));
    chk(bc == exp_n, {tag, " busy cycles"}, 64'(bc), 64'(exp_n));
    chk(!busy, "R10 busy low with rsp_valid", 64'(busy), 64'd0);
    for (int l = 0; l < LANES; l++)
      chk(rd_lane(l) === exp_rd[l], {tag, " R9 lane data"}, 64'(rd_lane(l)), 64'(exp_rd[l]));
    @(negedge clk);
    chk(!rsp_valid, "R9 single pulse", 64'(rsp_valid), 64'd0);
  endtask

  task automatic run_req(input string tag, input int exp_n);
    model_apply();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(tag, exp_n);
  endtask

  task automatic t_reset();
    clear_lanes();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_fill();
    for (int g = 0; g < WORDS / LANES; g++) begin
      for (int l = 0; l < LANES; l++) begin
        t_en[l] = 1'b1; t_we[l] = 1'b1;
        t_addr[l] = ADDR_W'(g*LANES + l);
        t_data[l] = 32'hA5A5_0000 ^ (g*LANES + l);
      end
      run_req("R4 unit-stride fill", 1);
    end
  endtask

  task automatic t_unit_read();
    for (int l = 0; l < LANES; l++) begin
      t_en[l] = 1'b1; t_we[l] = 1'b0; t_addr[l] = ADDR_W'(160 + l);
    end
    run_req("R4 unit-stride read", 1);
    // R2: the value read back is the one put at that address
    for (int l = 0; l < LANES; l++)
      chk(rd_lane(l) == (32'hA5A5_0000 ^ (160 + l)), "R2 address to word mapping",
          64'(rd_lane(l)), 64'(32'hA5A5_0000 ^ (160 + l)));
  endtask

  task automatic t_perm();
    for (int l = 0; l < LANES; l++) begin
      t_en[l] = 1'b1; t_we[l] = 1'b0; t_addr[l] = ADDR_W'(128 + ((l*5 + 3) % 16));
    end
    run_req("R4 permutation read", 1);
  endtask

  task automatic t_stride2();
    for (int l = 0; l < LANES; l++) begin
      t_en[l] = 1'b1; t_we[l] = 1'b0; t_addr[l] = ADDR_W'(256 + 2*l);
    end
    run_req("R5 stride-2 read", 2);
  endtask

  task automatic t_stride8();
    for (int l = 0; l < LANES; l++) begin
      t_en[l] = 1'b1; t_we[l] = 1'b1; t_addr[l] = ADDR_W'(8*l);
      t_data[l] = 32'h5000_0000 + l;
    end
    run_req("R5 stride-8 write", 8);
    for (int l = 0; l < LANES; l++) t_we[l] = 1'b0;
    run_req("R5 stride-8 read", 8);
  endtask

  task automatic t_order();
    clear_lanes();
    t_en[1] = 1'b1; t_addr[1] = 10'd53;
    t_en[2] = 1'b1; t_addr[2] = 10'd53; t_we[2] = 1'b1; t_data[2] = 32'hC0DE_0002;
    t_en[5] = 1'b1; t_addr[5] = 10'd53;
    run_req("R6 lowest lane first", 3);
    chk(rd_lane(1) == (32'hA5A5_0000 ^ 53), "R6 lower lane reads old word",
        64'(rd_lane(1)), 64'(32'hA5A5_0000 ^ 53));
    chk(rd_lane(5) == 32'hC0DE_0002, "R6 higher lane reads new word",
        64'(rd_lane(5)), 64'hC0DE_0002);
  endtask

  task automatic t_mask();
    clear_lanes();
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = ADDR_W'(3 + 16*l);
      if (l % 2 == 0) t_en[l] = 1'b1;
      else begin t_we[l] = 1'b1; t_data[l] = 32'hBAD0_0000 + l; end
    end
    run_req("R7 masked lanes not counted", 8);
    for (int l = 0; l < LANES; l++) begin
      t_en[l] = (l % 2 == 1); t_we[l] = 1'b0;
    end
    run_req("R7 masked writes left memory intact", 8);
    chk(rd_lane(1) == (32'hA5A5_0000 ^ 19), "R7 masked write had no effect",
        64'(rd_lane(1)), 64'(32'hA5A5_0000 ^ 19));
  endtask

  task automatic t_dup();
    for (int l = 0; l < LANES; l++) begin
      t_en[l] = 1'b1; t_we[l] = 1'b1; t_addr[l] = 10'd77; t_data[l] = 32'hD000_0000 + l;
    end
    run_req("R8 same-word writes serialized", 16);
    clear_lanes();
    t_en[0] = 1'b1; t_addr[0] = 10'd77;
    run_req("R8 read back", 1);
    chk(rd_lane(0) == 32'hD000_000F, "R8 last lane wins", 64'(rd_lane(0)), 64'hD000_000F);
  endtask

  task automatic t_busy_ignore();
    for (int l = 0; l < LANES; l++) begin
      t_en[l] = 1'b1; t_we[l] = 1'b0; t_addr[l] = ADDR_W'(8*l);
    end
    model_apply();
    req_valid = 1'b1;
    @(negedge clk);
    // intruder presented while busy: writes that must never land
    for (int l = 0; l < LANES; l++) begin
      t_we[l] = 1'b1; t_addr[l] = ADDR_W'(896 + l); t_data[l] = 32'hDEAD_0000 + l;
    end
    chk(busy === 1'b1, "R3 busy while serving", 64'(busy), 64'd1);
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    begin
      int k = 4, bc = 3;
      while (!rsp_valid && k < 80) begin
        if (busy) bc++;
        @(negedge clk); k++;
      end
      chk(k == 9 && bc == 8, "R3 busy span unchanged by intruder", 64'(k), 64'd9);
    end
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      t_we[l] = 1'b0; t_addr[l] = ADDR_W'(896 + l);
    end
    run_req("R3 intruder ignored", 1);
    chk(rd_lane(4) == (32'hA5A5_0000 ^ 900), "R3 no write while busy",
        64'(rd_lane(4)), 64'(32'hA5A5_0000 ^ 900));
  endtask

  task automatic t_none();
    clear_lanes();
    for (int l = 0; l < LANES; l++) begin
      t_we[l] = 1'b1; t_addr[l] = ADDR_W'(l); t_data[l] = 32'hFFFF_FFFF;
    end
    run_req("R9 empty mask", 0);
    clear_lanes();
    t_en[0] = 1'b1; t_addr[0] = 10'd0;
    run_req("R7 empty mask wrote nothing", 1);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_unit_read();
    t_perm();
    t_stride2();
    t_stride8();
    t_order();
    t_mask();
    t_dup();
    t_busy_ignore();
    t_none();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule